// File: doc/BRIEF.md
# Inverting Write-Verify Controller

This block controls the write of one data block into a memory whose cells can wear out and stay stuck at a fixed value. A supplied group map assigns every data bit to one of several groups, and the memory stores one flip flag per group next to the data. Each write is read back and compared. Any group that shows a mismatch is rewritten with its data inverted and its flag set. A stuck cell still reads back its stuck value, so inverting the group places the wanted value on the good cells and the inverted value on the stuck one. The stuck cell then holds the correct stored bit.

If the second read-back still mismatches, the group map cannot separate the faults. The controller then asks an external partition selector for a new map, as long as its per-write repartition count is below a limit, and restarts from the first write. Once the limit is reached it reports failure. A separate combinational read path takes stored cells and flags and returns user data, inverting back every group whose flag is set.

Top module: `ivw_ctrl`

## Requirements
- R1: `wr_ready` is high only when the controller is idle. A request is taken on a clock edge where `wr_valid` and `wr_ready` are both high, and no other request is taken until that write ends with `wr_done` or `wr_fail`.
- R2: The first write of a request, and every write that follows a repartition, drives `mem_we` with `mem_wdata` equal to the request data and every flip flag cleared. This happens in the cycle after the request is accepted, or after `rep_ack` is seen.
- R3: The cycle after any write is a read-back cycle with `mem_re` high. `mem_we` and `mem_re` are never high together. If the first read-back matches, `wr_done` pulses for one cycle, three cycles after acceptance.
- R4: On a mismatch in the first read-back, the next cycle writes again. Only the groups containing a mismatching bit have their flags set, and the data of exactly those groups is inverted.
- R5: If the second read-back matches, `wr_done` pulses one cycle later, five cycles after acceptance.
- R6: If the second read-back mismatches anywhere and fewer than `MAX_REPART` repartitions have happened for this request, `rep_req` rises and stays high until `rep_ack`. The next cycle restarts at the first write, under the new map.
- R7: If the second read-back mismatches after `MAX_REPART` repartitions, `wr_fail` pulses for one cycle and the controller returns to idle. `wr_done` and `wr_fail` are never high together.
- R8: `rd_data` equals `rd_cells`, with every bit whose group (per `grp_map`, bit i using field `grp_map[i*GRP_W +: GRP_W]`) has its `rd_flip` flag set inverted.
- R9: After reset the controller is idle, with `wr_ready` high and `mem_we`, `mem_re`, `rep_req`, `wr_done` and `wr_fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Controller idle, can take a request |
| wr_data | input | DATA_W | Data to store |
| grp_map | input | DATA_W*GRP_W | Group index of each data bit |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read-back strobe |
| mem_wdata | output | DATA_W | Cell values to write |
| mem_wflip | output | GROUPS | Flip flags to write |
| mem_rdata | input | DATA_W | Cell values read back (valid while mem_re) |
| rep_req | output | 1 | Repartition request |
| rep_ack | input | 1 | New group map is in place |
| wr_done | output | 1 | Write succeeded (one-cycle pulse) |
| wr_fail | output | 1 | Write failed (one-cycle pulse) |
| rd_cells | input | DATA_W | Stored cells for the read path |
| rd_flip | input | GROUPS | Stored flip flags for the read path |
| rd_data | output | DATA_W | Corrected read data |

## Verification
Assertions check, on every cycle, the ordering rules of the memory port. Writes and read-backs never overlap. A new request or a repartition acknowledge is always followed by a write with all flags cleared. The flags of the inverted write match the groups the detector marked. The repartition request holds until it is acknowledged. Done and fail never coincide. Whether the cells finally stored decode back to the request data, the exact done latency, and the number of repartitions before failure depend on the stuck-cell pattern and the map changes. Only the bench scenarios, with a faulty memory model and a partition selector, can show these.

// File: rtl/ivw_pkg.sv
package ivw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE1, ST_VERIFY1, ST_INVWRITE,
    ST_VERIFY2, ST_REPART, ST_DONE, ST_FAIL
  } ivw_state_e;
endpackage

// File: rtl/ivw_flip_expand.sv
module ivw_flip_expand #(
  parameter int DATA_W = 16,
  parameter int GROUPS = 4,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic [GROUPS-1:0]       flips,
  input  logic [DATA_W*GRP_W-1:0] grp_map,
  output logic [DATA_W-1:0]       mask
);
  // one mask bit per data bit: set when that bit's group is flagged
  function automatic logic bit_flag(input logic [GROUPS-1:0] f,
                                    input logic [GRP_W-1:0] g);
    return f[g];
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = bit_flag(flips, grp_map[i*GRP_W +: GRP_W]);
  end
endmodule

// File: rtl/ivw_grp_detect.sv
module ivw_grp_detect #(
  parameter int DATA_W = 16,
  parameter int GROUPS = 4,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic [DATA_W-1:0]       diff,
  input  logic [DATA_W*GRP_W-1:0] grp_map,
  output logic [GROUPS-1:0]       grp_bad,
  output logic                    any_bad
);
  function automatic logic group_hit(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W*GRP_W-1:0] m,
                                     input int g);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i] && (int'(m[i*GRP_W +: GRP_W]) == g)) hit = 1'b1;
    return hit;
  endfunction

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_bad[g] = group_hit(diff, grp_map, g);
  end
  assign any_bad = |diff;

  // R4: a mismatch always lands in some group
  always_comb begin
    any_bad_mapped_chk: assert (!any_bad || (grp_bad != '0));
  end
endmodule

// File: rtl/ivw_fsm.sv
module ivw_fsm
  import ivw_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int GROUPS     = 4,
  parameter int MAX_REPART = 3,
  localparam int CNT_W = $clog2(MAX_REPART + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [GROUPS-1:0] grp_bad,
  input  logic              any_bad,
  input  logic              rep_ack,
  output logic [DATA_W-1:0] data_q,
  output logic [GROUPS-1:0] flip_q,
  output logic              wr_ready,
  output logic              mem_we,
  output logic              mem_re,
  output logic              rep_req,
  output logic              wr_done,
  output logic              wr_fail
);
  ivw_state_e      state;
  logic [CNT_W-1:0] cnt_q;

  // named events for the checks
  logic accept_ev, v1_bad_ev, v2_ok_ev, v2_bad_ev, can_repart;
  assign accept_ev  = (state == ST_IDLE) && wr_valid;
  assign v1_bad_ev  = (state == ST_VERIFY1) && any_bad;
  assign v2_ok_ev   = (state == ST_VERIFY2) && !any_bad;
  assign v2_bad_ev  = (state == ST_VERIFY2) && any_bad;
  assign can_repart = cnt_q < CNT_W'(MAX_REPART);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
      flip_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (wr_valid) begin
          data_q <= wr_data;
          flip_q <= '0;
          cnt_q  <= '0;
          state  <= ST_WRITE1;
        end
        ST_WRITE1:  state <= ST_VERIFY1;
        ST_VERIFY1: if (any_bad) begin
          flip_q <= grp_bad;
          state  <= ST_INVWRITE;
        end else state <= ST_DONE;
        ST_INVWRITE: state <= ST_VERIFY2;
        ST_VERIFY2: if (!any_bad) state <= ST_DONE;
          else if (can_repart)    state <= ST_REPART;
          else                    state <= ST_FAIL;
        ST_REPART: if (rep_ack) begin
          cnt_q  <= cnt_q + 1'b1;
          flip_q <= '0;
          state  <= ST_WRITE1;
        end
        ST_DONE, ST_FAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_ready = (state == ST_IDLE);
  assign mem_we   = (state == ST_WRITE1) || (state == ST_INVWRITE);
  assign mem_re   = (state == ST_VERIFY1) || (state == ST_VERIFY2);
  assign rep_req  = (state == ST_REPART);
  assign wr_done  = (state == ST_DONE);
  assign wr_fail  = (state == ST_FAIL);

  // R2
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (mem_we && (flip_q == '0)));
  // R2
  ack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_req && rep_ack) |=> (mem_we && (flip_q == '0)));
  // R3
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R3
  write_then_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_re);
  // R4
  inv_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1_bad_ev |=> (mem_we && (flip_q == $past(grp_bad))));
  // R5
  v2_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2_ok_ev |=> wr_done);
  // R6
  rep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_req && !rep_ack) |=> rep_req);
  // R7
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_fail));
  // R7
  fail_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_bad_ev && !can_repart) |=> wr_fail);
  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || rep_req) |-> !wr_ready);
endmodule

// File: rtl/ivw_ctrl.sv
module ivw_ctrl #(
  parameter int DATA_W     = 16,
  parameter int GROUPS     = 4,
  parameter int MAX_REPART = 3,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W*GRP_W-1:0] grp_map,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [GROUPS-1:0]       mem_wflip,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    rep_req,
  input  logic                    rep_ack,
  output logic                    wr_done,
  output logic                    wr_fail,
  input  logic [DATA_W-1:0]       rd_cells,
  input  logic [GROUPS-1:0]       rd_flip,
  output logic [DATA_W-1:0]       rd_data
);
  logic [DATA_W-1:0] data_q, wr_mask, rd_mask, diff;
  logic [GROUPS-1:0] flip_q, grp_bad;
  logic              any_bad;

  ivw_fsm #(.DATA_W(DATA_W), .GROUPS(GROUPS), .MAX_REPART(MAX_REPART)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .grp_bad(grp_bad), .any_bad(any_bad), .rep_ack(rep_ack),
    .data_q(data_q), .flip_q(flip_q), .wr_ready(wr_ready),
    .mem_we(mem_we), .mem_re(mem_re), .rep_req(rep_req),
    .wr_done(wr_done), .wr_fail(wr_fail));

  // write side: invert flagged groups
  ivw_flip_expand #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_wr_exp (
    .flips(flip_q), .grp_map(grp_map), .mask(wr_mask));
  assign mem_wdata = data_q ^ wr_mask;
  assign mem_wflip = flip_q;

  // verify: cells read back against the pattern just written
  assign diff = mem_re ? (mem_rdata ^ mem_wdata) : '0;
  ivw_grp_detect #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_det (
    .diff(diff), .grp_map(grp_map), .grp_bad(grp_bad), .any_bad(any_bad));

  // read side: undo inversion
  ivw_flip_expand #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_rd_exp (
    .flips(rd_flip), .grp_map(grp_map), .mask(rd_mask));
  assign rd_data = rd_cells ^ rd_mask;

  // R8: unflagged read passes cells unchanged
  always_comb begin
    rd_pass_chk: assert (rd_flip != '0 || rd_data == rd_cells);
  end
endmodule

// File: tb/ivw_ctrl_test.sv
module ivw_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, NG = 4, GW = 2, MAXR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [DW*GW-1:0] grp_map;
  logic mem_we, mem_re, rep_req, wr_done, wr_fail;
  logic rep_ack = 1'b0;
  logic [DW-1:0] mem_wdata, mem_rdata, rd_data;
  logic [NG-1:0] mem_wflip;
  logic [DW-1:0] rd_cells = '0;
  logic [NG-1:0] rd_flip = '0;

  // memory model with stuck cells
  logic [DW-1:0] cells = '0, stuck_m = '0, stuck_v = '0;
  logic [NG-1:0] flips_st = '0;
  int writes = 0, reps = 0, ack_wait = 0;
  logic [DW*GW-1:0] next_map;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivw_ctrl #(.DATA_W(DW), .GROUPS(NG), .MAX_REPART(MAXR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .grp_map(grp_map), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_wflip(mem_wflip), .mem_rdata(mem_rdata),
    .rep_req(rep_req), .rep_ack(rep_ack), .wr_done(wr_done),
    .wr_fail(wr_fail), .rd_cells(rd_cells), .rd_flip(rd_flip),
    .rd_data(rd_data));

  assign mem_rdata = cells;

  always @(posedge clk) if (mem_we) begin
    cells    <= (mem_wdata & ~stuck_m) | (stuck_v & stuck_m);
    flips_st <= mem_wflip;
    writes   <= writes + 1;
  end

  // partition selector: acks two cycles into a request, installing next_map
  always @(negedge clk) begin
    if (rep_req && !rep_ack) begin
      ack_wait = ack_wait + 1;
      if (ack_wait == 2) begin
        rep_ack = 1'b1; grp_map = next_map; reps = reps + 1; ack_wait = 0;
      end
    end else rep_ack = 1'b0;
  end

  function automatic logic [DW*GW-1:0] mk_map(input bit by_nibble);
    logic [DW*GW-1:0] m;
    for (int i = 0; i < DW; i++)
      m[i*GW +: GW] = by_nibble ? GW'(i / 4) : GW'(i % 4);
    return m;
  endfunction

  function automatic logic [DW-1:0] decode(input logic [DW-1:0] c,
      input logic [NG-1:0] f, input logic [DW*GW-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = c[i] ^ f[int'(m[i*GW +: GW])];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue a write and count negedges until completion
  task automatic run_write(input logic [DW-1:0] d, output int cyc, output bit failed);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_valid = 1'b0;
    cyc = 1;
    check("R1 ready low while busy", wr_ready, 0);
    while (!(wr_done || wr_fail) && cyc < 300) begin
      @(negedge clk); cyc++;
    end
    failed = wr_fail;
  endtask

  task automatic t_reset;
    check("R9 ready", wr_ready, 1);
    check("R9 strobes", {mem_we, mem_re, rep_req, wr_done, wr_fail}, 0);
  endtask

  task automatic t_clean(input logic [DW-1:0] d, input logic [DW-1:0] sm, input logic [DW-1:0] sv);
    int cyc, w0; bit f;
    stuck_m = sm; stuck_v = sv; grp_map = mk_map(0); w0 = writes;
    run_write(d, cyc, f);
    check("R3 done latency", cyc, 3);
    check("R3 not failed", f, 0);
    check("R2 single write", writes - w0, 1);
    check("R2 flags cleared", flips_st, 0);
    check("R2 stored data", cells, d);
  endtask

  task automatic t_single_stuck;
    int cyc, w0; bit f;
    stuck_m = 16'h0020; stuck_v = 16'h0000; grp_map = mk_map(0); w0 = writes;
    run_write(16'h00FF, cyc, f);
    check("R5 done latency", cyc, 5);
    check("R4 two writes", writes - w0, 2);
    check("R4 only group1 flagged", flips_st, 4'b0010);
    check("R4 decoded data", decode(cells, flips_st, grp_map), 16'h00FF);
  endtask

  task automatic t_repart_ok;
    int cyc, w0, r0; bit f;
    stuck_m = 16'h0022; stuck_v = 16'h0020; grp_map = mk_map(0);
    next_map = mk_map(1); w0 = writes; r0 = reps;
    run_write(16'h00FF, cyc, f);
    check("R6 success", f, 0);
    check("R6 one repartition", reps - r0, 1);
    check("R6 four writes", writes - w0, 4);
    check("R6 group0 flagged", flips_st, 4'b0001);
    check("R6 decoded data", decode(cells, flips_st, grp_map), 16'h00FF);
  endtask

  task automatic t_fail;
    int cyc, w0, r0; bit f;
    stuck_m = 16'h0022; stuck_v = 16'h0020; grp_map = mk_map(0);
    next_map = mk_map(0); w0 = writes; r0 = reps;
    run_write(16'h00FF, cyc, f);
    check("R7 failed", f, 1);
    check("R7 done low", wr_done, 0);
    check("R7 repartitions at limit", reps - r0, MAXR);
    check("R7 writes", writes - w0, 2 * (MAXR + 1));
    @(negedge clk);
    check("R7 back to idle", wr_ready, 1);
  endtask

  task automatic t_read(input logic [DW-1:0] c, input logic [NG-1:0] f, input bit mp);
    grp_map = mk_map(mp);
    rd_cells = c; rd_flip = f;
    #1;
    check("R8 read decode", rd_data, decode(c, f, mk_map(mp)));
  endtask

  initial begin
    grp_map = mk_map(0); next_map = mk_map(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(16'hA53C, 16'h0000, 16'h0000);
    t_clean(16'h00FF, 16'h0200, 16'h0000);
    t_single_stuck();
    t_repart_ok();
    t_fail();
    t_read(16'hA5A5, 4'b1001, 0);
    check("R8 fixed value", rd_data, 16'h3C3C);
    t_read(16'h1234, 4'b0100, 1);
    t_read(16'hFFFF, 4'b0000, 0);
    t_read(16'h0F0F, 4'b1111, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule